// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block watches one of two free-running 16-bit timers and compares its count with a programmable 16-bit compare value. When the selected timer first becomes equal to the compare value, the unit sets a sticky interrupt flag. It also carries out the action chosen by a 4-bit mode field. The action can drive an output latch high, drive it low, toggle it, leave it alone, or fire an event trigger. The event trigger clears the selected timer and starts an analog-to-digital conversion, and it does not raise the overflow flag that the timer itself owns.

Software sets up the unit through a small byte-wide write port with four locations. Location 0 holds the low byte of the compare value and location 1 the high byte. Location 2 is the control byte: bits 3:0 hold the mode, bit 4 selects the timer (0 = timer A, 1 = timer B), and bit 5 enables the output. Writing location 3 with bit 0 set clears the interrupt flag. The output pin is driven from a set/reset latch, and the pin is only driven while the output-enable bit is set.

Mode codes:
- 0000: the unit is off.
- 1000: the latch is set on a match.
- 1001: the latch is cleared on a match.
- 0010: the latch toggles on a match.
- 1010: a match sets only the flag.
- 1011: a match fires the event trigger.
- Any other code behaves like off.

Top module: `tmr_match_unit`

## Requirements
- R1: After synchronous reset, `pin_out`, `pin_oe`, `irq_flag`, `adc_start`, `tmr_a_clr` and `tmr_b_clr` are all 0, and the compare value, control byte and latch are 0.
- R2: The comparison is an equality test on all 16 bits of the timer that control bit 4 selects (0 = `tmr_a`, 1 = `tmr_b`). If the unselected timer equals the compare value, nothing happens, and a count that differs from the compare value in any single bit is not a match.
- R3: In an enabled mode (1000, 1001, 0010, 1010, 1011), `irq_flag` is 1 from the first clock edge at which the selected count equals the compare value. It then stays 1 until software clears it.
- R4: A match fires once for each equality event. A count that stays equal for further cycles does not fire again, so once the flag has been cleared it stays 0 while the count is held.
- R5: Writing location 3 with bit 0 = 1 clears `irq_flag` at the next edge. If a match arrives on the same edge as the clear, the match wins and the flag ends up 1.
- R6: On a match, the latch is set to 1 in mode 1000, set to 0 in mode 1001, and inverted in mode 0010. In modes 1010 and 1011 the latch is left unchanged.
- R7: Any write to the control byte loads the latch with the inactive level of the new mode: 1 for mode 1001 and 0 for every other code.
- R8: In mode 1011, a match produces a pulse of exactly one cycle on `adc_start`. On the same edge it produces a pulse on the clear output of the selected timer only (`tmr_a_clr` or `tmr_b_clr`).
- R9: `pin_oe` equals control bit 5. `pin_out` shows the latch when that bit is 1 and is 0 when it is 0.
- R10: In mode 0000, and under any code not listed, a match sets no flag, produces no trigger and leaves the latch at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register location (0 compare low, 1 compare high, 2 control, 3 flag clear) |
| wr_data | input | 8 | Write data |
| tmr_a | input | 16 | Count of timer A |
| tmr_b | input | 16 | Count of timer B |
| tmr_a_clr | output | 1 | One-cycle synchronous clear request to timer A |
| tmr_b_clr | output | 1 | One-cycle synchronous clear request to timer B |
| pin_out | output | 1 | Output pin level (latch gated by output enable) |
| pin_oe | output | 1 | Output pin drive enable |
| irq_flag | output | 1 | Sticky compare interrupt flag |
| adc_start | output | 1 | One-cycle conversion start strobe |

## Verification
Every piece of state in this block shows up at the ports within one clock edge of the event that should change it:
- A wrong equality bit or timer select shows up as a flag that fails to rise, or rises at the wrong time, in the first cycle after the count is applied.
- A broken edge detector shows up as a flag that comes back after a clear while the count is held.
- A corrupt latch or a wrong mode decode shows up on `pin_out` right after the control write or the match edge.
- A broken trigger path shows up as a pulse that is missing, lasts two cycles, or goes to the wrong timer's clear.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam int NBYTES = CNT_W / DATA_W;

    localparam logic [ADDR_W-1:0] LOC_CTRL = ADDR_W'(NBYTES);
    localparam logic [ADDR_W-1:0] LOC_FLAG = ADDR_W'(NBYTES + 1);

    localparam logic [3:0] MODE_OFF    = 4'b0000;
    localparam logic [3:0] MODE_TOGGLE = 4'b0010;
    localparam logic [3:0] MODE_SET    = 4'b1000;
    localparam logic [3:0] MODE_CLR    = 4'b1001;
    localparam logic [3:0] MODE_FLAG   = 4'b1010;
    localparam logic [3:0] MODE_TRIG   = 4'b1011;

    typedef struct packed {
        logic       oe;
        logic       sel;
        logic [3:0] mode;
    } ctrl_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_SET,
        ACT_CLR,
        ACT_TOG,
        ACT_HOLD,
        ACT_TRIG
    } act_e;

    function automatic act_e decode_act(input logic [3:0] m);
        case (m)
            MODE_SET:    return ACT_SET;
            MODE_CLR:    return ACT_CLR;
            MODE_TOGGLE: return ACT_TOG;
            MODE_FLAG:   return ACT_HOLD;
            MODE_TRIG:   return ACT_TRIG;
            default:     return ACT_NONE;
        endcase
    endfunction

    function automatic logic latch_idle(input logic [3:0] m);
        return m == MODE_CLR;
    endfunction

endpackage

// File: rtl/tmu_regs.sv
module tmu_regs
    import tmu_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [CW-1:0] cmp_val,
    output ctrl_t         ctrl,
    output logic          ctrl_wr,
    output logic          flag_clr
);

    localparam int NB = CW / DW;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_val[b*DW +: DW] <= '0;
            end else if (wr_en && wr_addr == AW'(b)) begin
                cmp_val[b*DW +: DW] <= wr_data;
            end
        end
    end

    assign ctrl_wr  = wr_en && (wr_addr == LOC_CTRL);
    assign flag_clr = wr_en && (wr_addr == LOC_FLAG) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
        end
    end

endmodule

// File: rtl/tmu_match.sv
module tmu_match #(
    parameter int CW = tmu_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_a,
    input  logic [CW-1:0] cnt_b,
    input  logic          sel,
    input  logic [CW-1:0] cmp_val,
    input  logic          enable,
    output logic          hit
);

    logic [CW-1:0] cnt_sel;
    logic          eq;
    logic          eq_prev;

    assign cnt_sel = sel ? cnt_b : cnt_a;
    assign eq      = (cnt_sel == cmp_val);
    assign hit     = enable && eq && !eq_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            eq_prev <= 1'b0;
        end else begin
            eq_prev <= eq;
        end
    end

endmodule

// File: rtl/tmu_out.sv
module tmu_out
    import tmu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic [3:0] mode,
    input  logic       sel,
    input  logic       ctrl_wr,
    input  logic [3:0] new_mode,
    input  logic       flag_clr,
    output logic       latch,
    output logic       flag,
    output logic       trig,
    output logic       trig_sel
);

    act_e act;

    assign act = decode_act(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch <= 1'b0;
        end else if (ctrl_wr) begin
            latch <= latch_idle(new_mode);
        end else if (hit) begin
            case (act)
                ACT_SET: latch <= 1'b1;
                ACT_CLR: latch <= 1'b0;
                ACT_TOG: latch <= !latch;
                default: latch <= latch;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig     <= 1'b0;
            trig_sel <= 1'b0;
        end else begin
            trig     <= hit && (act == ACT_TRIG);
            trig_sel <= sel;
        end
    end

endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit
    import tmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  tmr_a,
    input  logic [CNT_W-1:0]  tmr_b,
    output logic              tmr_a_clr,
    output logic              tmr_b_clr,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq_flag,
    output logic              adc_start
);

    logic [CNT_W-1:0] cmp_val;
    ctrl_t            ctrl;
    logic             ctrl_wr;
    logic             flag_clr;
    logic             hit;
    logic             latch;
    logic             trig;
    logic             trig_sel;
    logic             enabled;

    assign enabled = decode_act(ctrl.mode) != ACT_NONE;

    tmu_regs #(.CW(CNT_W), .DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cmp_val  (cmp_val),
        .ctrl     (ctrl),
        .ctrl_wr  (ctrl_wr),
        .flag_clr (flag_clr)
    );

    tmu_match #(.CW(CNT_W)) u_match (
        .clk     (clk),
        .rst     (rst),
        .cnt_a   (tmr_a),
        .cnt_b   (tmr_b),
        .sel     (ctrl.sel),
        .cmp_val (cmp_val),
        .enable  (enabled),
        .hit     (hit)
    );

    tmu_out u_out (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .mode     (ctrl.mode),
        .sel      (ctrl.sel),
        .ctrl_wr  (ctrl_wr),
        .new_mode (wr_data[3:0]),
        .flag_clr (flag_clr),
        .latch    (latch),
        .flag     (irq_flag),
        .trig     (trig),
        .trig_sel (trig_sel)
    );

    assign pin_oe    = ctrl.oe;
    assign pin_out   = latch && ctrl.oe;
    assign adc_start = trig;
    assign tmr_a_clr = trig && !trig_sel;
    assign tmr_b_clr = trig && trig_sel;

endmodule

// File: rtl/tmu_checker.sv
module tmu_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       tmr_a_clr,
    input logic       tmr_b_clr,
    input logic       pin_out,
    input logic       pin_oe,
    input logic       irq_flag,
    input logic       adc_start
);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_flag && !adc_start && !pin_oe && !pin_out && !tmr_a_clr && !tmr_b_clr));

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_flag) && !($past(wr_en) && $past(wr_addr) == 2'd3 && $past(wr_data[0]))) |-> irq_flag);

    a_r3_flag_with_trigger: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> irq_flag);

    a_r8_single_cycle_start: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

    a_r8_one_timer_cleared: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tmr_a_clr, tmr_b_clr}));

    a_r9_pin_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !pin_oe |-> !pin_out);

endmodule

bind tmr_match_unit tmu_checker u_tmu_checker (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tmr_a_clr (tmr_a_clr),
    .tmr_b_clr (tmr_b_clr),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_flag  (irq_flag),
    .adc_start (adc_start)
);

// File: tb/test_tmr_match_unit.sv
module test_tmr_match_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] tmr_a = '0;
    logic [15:0] tmr_b = '0;
    logic        tmr_a_clr, tmr_b_clr, pin_out, pin_oe, irq_flag, adc_start;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    localparam logic [15:0] CMP = 16'h1234;

    always #5 clk = ~clk;

    tmr_match_unit i_tmr_match_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tmr_a(tmr_a), .tmr_b(tmr_b), .tmr_a_clr(tmr_a_clr), .tmr_b_clr(tmr_b_clr),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_flag(irq_flag), .adc_start(adc_start)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic set_cmp(input logic [15:0] v);
        wr(2'd0, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    task automatic set_ctrl(input logic oe, input logic sel, input logic [3:0] m);
        wr(2'd2, {2'b00, oe, sel, m});
    endtask

    task automatic set_sel_tmr(input logic sel, input logic [15:0] v);
        if (sel) tmr_b = v; else tmr_a = v;
    endtask

    function automatic bit mode_on(input logic [3:0] m);
        return m == 4'b1000 || m == 4'b1001 || m == 4'b0010 || m == 4'b1010 || m == 4'b1011;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 pin_out", pin_out, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 irq_flag", irq_flag, 0);
        chk("R1 adc_start", adc_start, 0);
        chk("R1 clears", {tmr_a_clr, tmr_b_clr}, 0);

        // Basic set-on-match, hold, clear
        set_cmp(CMP);
        set_ctrl(1'b1, 1'b0, 4'b1000);
        chk("R7 set mode idle low", pin_out, 0);
        tmr_a = CMP;
        step();
        chk("R3 flag on match", irq_flag, 1);
        chk("R6 set on match", pin_out, 1);
        step();
        wr(2'd3, 8'h01);
        chk("R5 flag cleared", irq_flag, 0);
        step(); step();
        chk("R4 held count no refire", irq_flag, 0);
        tmr_a = 16'h0;
        step();

        // Sweep all mode codes on both timers
        for (int m = 0; m < 16; m++) begin
            for (int s = 0; s < 2; s++) begin
                logic [3:0] md;
                bit on, trg, init, e1, e2;
                md   = 4'(m);
                on   = mode_on(md);
                trg  = (md == 4'b1011);
                init = (md == 4'b1001);
                case (md)
                    4'b1000: begin e1 = 1; e2 = 1; end
                    4'b1001: begin e1 = 0; e2 = 0; end
                    4'b0010: begin e1 = 1; e2 = 0; end
                    default: begin e1 = init; e2 = init; end
                endcase
                tmr_a = 16'h0; tmr_b = 16'h0;
                step();
                wr(2'd3, 8'h01);
                set_ctrl(1'b1, s[0], md);
                chk("R7 idle level after mode write", pin_out, init);
                chk("R9 oe follows control", pin_oe, 1);
                set_sel_tmr(!s[0], CMP);
                step();
                chk("R2 unselected timer ignored", irq_flag, 0);
                set_sel_tmr(!s[0], 16'h0);
                set_sel_tmr(s[0], CMP);
                step();
                chk("R3 R10 flag per mode", irq_flag, on);
                chk("R8 start pulse", adc_start, trg);
                chk("R8 selected clear", {tmr_b_clr, tmr_a_clr},
                    trg ? (s ? 32'd2 : 32'd1) : 32'd0);
                chk("R6 R10 pin after first match", pin_out, e1);
                step();
                chk("R8 pulse one cycle", adc_start, 0);
                set_sel_tmr(s[0], 16'h0);
                step();
                set_sel_tmr(s[0], CMP);
                step();
                chk("R6 pin after second match", pin_out, e2);
            end
        end

        // Single-bit sweep of the compare value
        set_ctrl(1'b1, 1'b0, 4'b1010);
        for (int i = 0; i < 16; i++) begin
            logic [15:0] v;
            v = 16'h1 << i;
            tmr_a = 16'h0;
            set_cmp(v);
            wr(2'd3, 8'h01);
            step();
            chk("R2 near miss no match", irq_flag, 0);
            tmr_a = v;
            step();
            chk("R2 exact bit match", irq_flag, 1);
        end

        // Clear and match on the same edge
        set_cmp(CMP);
        tmr_a = 16'h0;
        step();
        tmr_a = CMP;
        step();
        tmr_a = 16'h0;
        step();
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01; tmr_a = CMP;
        step();
        wr_en = 1'b0;
        chk("R5 match beats clear", irq_flag, 1);
        wr(2'd3, 8'h01);
        chk("R5 plain clear", irq_flag, 0);

        // Output enable gating
        set_ctrl(1'b0, 1'b0, 4'b1001);
        chk("R9 pin_oe low", pin_oe, 0);
        chk("R9 pin gated", pin_out, 0);
        set_ctrl(1'b1, 1'b0, 4'b1001);
        chk("R9 pin shows latch", pin_out, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule